// File: doc/BRIEF.md
# Dual-Mode Bit-Serial Adder

The block adds two unsigned operands one bit per clock through a single full adder and a carry flip-flop. Two operand shift registers of `N` bits feed the adder least-significant bit first. A result shift register of `N+1` bits collects each sum bit at its top end, so after `N+1` shifts it holds the whole sum with the final carry as its MSB.

There are two ways to supply operands. In parallel mode a one-cycle strobe captures both words and the addition runs by itself. The result is then presented as a word and held, with the valid flag high. In streaming mode the caller raises an enable and feeds one bit of each operand per clock. The block emits one sum bit per clock on a serial output, a fixed number of cycles later. Because the carry runs on from bit to bit, the streamed operands may be of any length. The valid flag is high only while the output bit is a true sum bit and the enable is still high.

The controller is a five-state machine. `ST_IDLE` moves to `ST_S_ARM` when the enable is seen. `ST_S_ARM` moves to `ST_S_RUN` if the enable is still high, and back to `ST_IDLE` if it is not. `ST_S_RUN` returns to `ST_IDLE` when the enable falls. `ST_P_RUN` moves to `ST_P_DONE` after `N+1` shifts. `ST_P_DONE` moves to `ST_S_ARM` on the enable. From every state, the strobe leads to `ST_P_RUN`, and an active-high synchronous reset leads to `ST_IDLE`.

Top module: `bitser_add`

## Requirements
- R1: While `rst` is high at a clock edge, all registers clear. After that edge `sum_word` is 0, `sum_bit` is 0 and `sum_ok` is 0.
- R2: When `par_go` is sampled high at edge L, `sum_word` equals `opa_par + opb_par` (the `N+1`-bit sum, bit N the carry-out) from edge L+N+1 on. `sum_ok` is 1 from that edge on. Both hold until the next start.
- R3: `sum_ok` is 0 from edge L until edge L+N+1, while a parallel addition is running.
- R4: A `par_go` sampled while an addition runs restarts it with the new operands. The old result is never flagged valid.
- R5: `par_go` wins over `ser_en` in the same cycle. `ser_en` has no effect while a parallel addition runs.
- R6: Let E be the first edge at which `ser_en` is sampled high from `ST_IDLE` or `ST_P_DONE`. The serial inputs are ignored at edges E and E+1. Bit k of each operand (LSB first) is sampled at edge E+2+k.
- R7: Sum bit k appears on `sum_bit` after edge E+2+k+N. `sum_ok` is 1 from edge E+2+N on while `ser_en` stays high. For N=6 the first bit is therefore shown after the 9th edge, counting E as the first.
- R8: Whenever `ser_en` is low outside `ST_P_DONE`, `sum_ok` is 0 in the same cycle. A low `ser_en` sampled in streaming mode ends the run. The next rise starts over with the carry cleared.
- R9: The carry runs through the whole stream, so operands longer than N add correctly. With N=6, 37 + 30 streamed as 7 bits gives 1000011 (67).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| par_go | input | 1 | Strobe that captures both parallel operands and starts the addition |
| opa_par | input | N | Parallel operand A |
| opb_par | input | N | Parallel operand B |
| ser_en | input | 1 | Streaming enable |
| opa_bit | input | 1 | Streamed bit of operand A, LSB first |
| opb_bit | input | 1 | Streamed bit of operand B, LSB first |
| sum_word | output | N+1 | Result register contents; the sum when a parallel addition is done |
| sum_bit | output | 1 | Most recently produced sum bit |
| sum_ok | output | 1 | Output qualifies as a valid result |

## Verification
Two events can land in the same cycle: the start strobe and the streaming enable. They can also overlap in time, with the enable arriving while a parallel addition is still shifting. The bench raises the strobe and the enable together, then keeps the enable high for several more cycles of the run. Its model requires the parallel sum to appear `N+1` edges after the strobe, with no serial run started. A second overlap is a strobe during a run that is still shifting. For that case the bench expects the new operands' sum, and the first result must never be flagged valid.

// File: rtl/bsa_pkg.sv
package bsa_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_S_ARM,
        ST_S_RUN,
        ST_P_RUN,
        ST_P_DONE
    } bsa_state_e;

    typedef enum logic [1:0] {
        DP_HOLD,
        DP_LOAD,
        DP_CLEAR,
        DP_SHIFT
    } bsa_cmd_e;

endpackage

// File: rtl/bsa_fa.sv
module bsa_fa (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic s,
    output logic cout
);
    always_comb begin
        s    = x ^ y ^ cin;
        cout = (x & y) | (cin & (x ^ y));
    end
endmodule

// File: rtl/bsa_datapath.sv
module bsa_datapath
    import bsa_pkg::*;
#(
    parameter int N = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  bsa_cmd_e       cmd,
    input  logic [N-1:0]   par_a,
    input  logic [N-1:0]   par_b,
    input  logic           ins_a,
    input  logic           ins_b,
    output logic [N:0]     res_q,
    output logic           res_top
);
    localparam int RW = N + 1;

    logic [N-1:0]  a_q, b_q;
    logic          carry_q;
    logic          fa_s, fa_c;

    bsa_fa u_fa (
        .x    (a_q[0]),
        .y    (b_q[0]),
        .cin  (carry_q),
        .s    (fa_s),
        .cout (fa_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q     <= '0;
            b_q     <= '0;
            carry_q <= 1'b0;
            res_q   <= '0;
        end else begin
            unique case (cmd)
                DP_LOAD: begin
                    a_q     <= par_a;
                    b_q     <= par_b;
                    carry_q <= 1'b0;
                    res_q   <= '0;
                end
                DP_CLEAR: begin
                    a_q     <= '0;
                    b_q     <= '0;
                    carry_q <= 1'b0;
                    res_q   <= '0;
                end
                DP_SHIFT: begin
                    if (N > 1) begin
                        a_q <= {ins_a, a_q[N-1:1]};
                        b_q <= {ins_b, b_q[N-1:1]};
                    end else begin
                        a_q <= N'(ins_a);
                        b_q <= N'(ins_b);
                    end
                    carry_q <= fa_c;
                    res_q   <= {fa_s, res_q[RW-1:1]};
                end
                DP_HOLD: ;
                default: ;
            endcase
        end
    end

    assign res_top = res_q[N];

    // R1 / R9: every load or clear starts the carry chain from zero
    a_r1_carry_cleared: assert property (@(posedge clk) disable iff (rst)
        (cmd == DP_LOAD || cmd == DP_CLEAR) |=> (carry_q == 1'b0));

endmodule

// File: rtl/bsa_ctrl.sv
module bsa_ctrl
    import bsa_pkg::*;
#(
    parameter int N = 6
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     par_go,
    input  logic     ser_en,
    output bsa_cmd_e cmd,
    output logic     ser_sel,
    output logic     p_done,
    output logic     s_valid
);
    localparam int              CW       = $clog2(N + 2);
    localparam logic [CW-1:0]   CNT_LAST = CW'(N);

    bsa_state_e    st, st_nx;
    logic [CW-1:0] cnt;

    // next-state selection
    always_comb begin
        st_nx = st;
        if (par_go) begin
            st_nx = ST_P_RUN;
        end else begin
            unique case (st)
                ST_IDLE,
                ST_P_DONE: if (ser_en) st_nx = ST_S_ARM;
                ST_S_ARM:  st_nx = ser_en ? ST_S_RUN : ST_IDLE;
                ST_S_RUN:  if (!ser_en) st_nx = ST_IDLE;
                ST_P_RUN:  if (cnt == CNT_LAST) st_nx = ST_P_DONE;
                default:   st_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_IDLE;
        else     st <= st_nx;
    end

    // shift counter and streaming valid flag
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            s_valid <= 1'b0;
        end else begin
            s_valid <= 1'b0;
            if (par_go) begin
                cnt <= '0;
            end else begin
                unique case (st)
                    ST_P_RUN: cnt <= cnt + 1'b1;
                    ST_S_RUN: begin
                        if (ser_en) begin
                            if (cnt != CNT_LAST) cnt <= cnt + 1'b1;
                            s_valid <= (cnt == CNT_LAST);
                        end else begin
                            cnt <= '0;
                        end
                    end
                    default: cnt <= '0;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        cmd     = DP_HOLD;
        ser_sel = (st == ST_S_RUN);
        p_done  = (st == ST_P_DONE);
        if (par_go) begin
            cmd = DP_LOAD;
        end else begin
            unique case (st)
                ST_IDLE,
                ST_P_DONE: cmd = ser_en ? DP_CLEAR : DP_HOLD;
                ST_S_ARM:  cmd = DP_HOLD;
                ST_S_RUN:  cmd = ser_en ? DP_SHIFT : DP_HOLD;
                ST_P_RUN:  cmd = DP_SHIFT;
                default:   cmd = DP_HOLD;
            endcase
        end
    end

    // R4: a strobe always restarts from a clean count
    a_r4_strobe_restarts: assert property (@(posedge clk) disable iff (rst)
        par_go |=> (st == ST_P_RUN && cnt == '0));

    // R6: the arming state lasts exactly one cycle
    a_r6_arm_single_cycle: assert property (@(posedge clk) disable iff (rst)
        (st == ST_S_ARM) |=> (st != ST_S_ARM));

    // R2: completion only after the full N+1 shifts
    a_r2_done_after_count: assert property (@(posedge clk) disable iff (rst)
        $rose(p_done) |-> ($past(cnt) == CNT_LAST));

endmodule

// File: rtl/bitser_add.sv
module bitser_add
    import bsa_pkg::*;
#(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         par_go,
    input  logic [N-1:0] opa_par,
    input  logic [N-1:0] opb_par,
    input  logic         ser_en,
    input  logic         opa_bit,
    input  logic         opb_bit,
    output logic [N:0]   sum_word,
    output logic         sum_bit,
    output logic         sum_ok
);
    bsa_cmd_e cmd;
    logic     ser_sel, p_done, s_valid;
    logic     ins_a, ins_b;

    bsa_ctrl #(.N(N)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .par_go  (par_go),
        .ser_en  (ser_en),
        .cmd     (cmd),
        .ser_sel (ser_sel),
        .p_done  (p_done),
        .s_valid (s_valid)
    );

    // streamed bits enter only in streaming run; parallel shifts fill zeros
    assign ins_a = ser_sel & opa_bit;
    assign ins_b = ser_sel & opb_bit;

    bsa_datapath #(.N(N)) u_dp (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .par_a   (opa_par),
        .par_b   (opb_par),
        .ins_a   (ins_a),
        .ins_b   (ins_b),
        .res_q   (sum_word),
        .res_top (sum_bit)
    );

    assign sum_ok = p_done | (s_valid & ser_en);

    // R3: the cycle after a strobe never shows a valid result
    a_r3_no_valid_after_strobe: assert property (@(posedge clk) disable iff (rst)
        par_go |=> !sum_ok);

    // R2: a finished parallel result is held steady
    a_r2_result_held: assert property (@(posedge clk) disable iff (rst)
        (p_done && $past(p_done) && !$past(par_go)) |-> $stable(sum_word));

endmodule

// File: tb/bitser_add_test.sv
module bitser_add_test;
    localparam int W = 6;
    localparam int M_IDLE = 0, M_ARM = 1, M_RUN = 2, M_P = 3, M_PD = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         par_go = 1'b0;
    logic [W-1:0] opa_par = '0, opb_par = '0;
    logic         ser_en = 1'b0, opa_bit = 1'b0, opb_bit = 1'b0;
    logic [W:0]   sum_word;
    logic         sum_bit, sum_ok;

    int n_cmp = 0, n_bad = 0, cycles = 0;

    bitser_add #(.N(W)) uut (
        .clk(clk), .rst(rst), .par_go(par_go), .opa_par(opa_par),
        .opb_par(opb_par), .ser_en(ser_en), .opa_bit(opa_bit),
        .opb_bit(opb_bit), .sum_word(sum_word), .sum_bit(sum_bit),
        .sum_ok(sum_ok)
    );

    always #2.5 clk = ~clk;

    // behavioural reference model
    int   m = M_IDLE, pc = 0, ptarget = 0, carry = 0;
    bit   sv = 1'b0, eb = 1'b0;
    bit   q[$];
    bit [63:0] col_v;
    int   col_n = 0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m = M_IDLE; sv = 0; pc = 0; q.delete();
        end else if (par_go) begin
            m = M_P; pc = 0; sv = 0;
            ptarget = int'(opa_par) + int'(opb_par);
        end else begin
            case (m)
                M_P: begin
                    pc++;
                    if (pc == W + 1) m = M_PD;
                end
                M_IDLE, M_PD: if (ser_en) begin m = M_ARM; sv = 0; end
                M_ARM: begin
                    if (ser_en) begin m = M_RUN; carry = 0; q.delete(); end
                    else m = M_IDLE;
                end
                M_RUN: begin
                    if (!ser_en) begin
                        m = M_IDLE; sv = 0;
                    end else begin
                        int s;
                        s = int'(opa_bit) + int'(opb_bit) + carry;
                        carry = s / 2;
                        q.push_back(s[0]);
                        if (q.size() > W) begin eb = q.pop_front(); sv = 1; end
                    end
                end
                default: m = M_IDLE;
            endcase
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (!rst) begin
            bit exp_ok;
            string tag;
            exp_ok = (m == M_PD) || (sv && ser_en);
            tag = (m == M_PD) ? "R2" : (m == M_P) ? "R3" :
                  (m == M_RUN) ? "R7" : "R8";
            n_cmp++;
            if (sum_ok !== exp_ok) begin
                n_bad++;
                $display("FAIL %s sum_ok actual=%0b expected=%0b t=%0t", tag, sum_ok, exp_ok, $time);
            end
            if (m == M_PD) begin
                n_cmp++;
                if (sum_word !== (W+1)'(ptarget)) begin
                    n_bad++;
                    $display("FAIL R2 sum_word actual=%0d expected=%0d", sum_word, ptarget);
                end
            end
            if (sv && ser_en && m == M_RUN) begin
                n_cmp++;
                if (sum_bit !== eb) begin
                    n_bad++;
                    $display("FAIL R7 sum_bit actual=%0b expected=%0b t=%0t", sum_bit, eb, $time);
                end
                if (sum_ok && col_n < 64) begin
                    col_v[col_n] = sum_bit;
                    col_n++;
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic par_add(input int a, input int b, input int wait_n);
        par_go = 1'b1; opa_par = W'(a); opb_par = W'(b);
        tick();
        par_go = 1'b0;
        for (int i = 0; i < wait_n; i++) tick();
    endtask

    task automatic ser_add(input longint a, input longint b, input int nb);
        longint exp;
        col_n = 0; col_v = '0;
        ser_en = 1'b1; opa_bit = 1'b1; opb_bit = 1'b1;  // ignored edges (R6)
        tick(); tick();
        for (int k = 0; k < nb + W + 1; k++) begin
            opa_bit = (k < nb) ? a[k] : 1'b0;
            opb_bit = (k < nb) ? b[k] : 1'b0;
            tick();
        end
        opa_bit = 1'b0; opb_bit = 1'b0;
        tick();
        ser_en = 1'b0;
        @(negedge clk);
        check("R8 sum_ok after enable drop", sum_ok, 0);
        exp = a + b;
        check("R9 streamed sum", longint'(col_v & ((64'd1 << (nb + 1)) - 1)), exp);
        check("R6 valid bit count", col_n >= nb + 1, 1);
        tick();
    endtask

    initial begin
        repeat (3) tick();
        @(negedge clk);
        check("R1 sum_ok in reset", sum_ok, 0);
        check("R1 sum_word in reset", sum_word, 0);
        check("R1 sum_bit in reset", sum_bit, 0);
        rst = 1'b0;
        tick();

        par_add(37, 30, W + 3);
        check("R2 37+30", sum_word, 67);
        par_add(63, 63, W + 3);
        check("R2 carry out", sum_word, 126);
        par_add(0, 0, W + 3);
        check("R2 zeros", sum_word, 0);
        par_add(63, 1, W + 1);
        @(negedge clk);
        check("R2 valid at N+1", sum_ok, 1);
        check("R2 63+1", sum_word, 64);
        tick();

        par_add(5, 9, 2);
        par_add(40, 17, W + 2);
        check("R4 restart result", sum_word, 57);

        // R5: strobe and enable together, enable held during the run
        par_go = 1'b1; ser_en = 1'b1; opa_par = W'(21); opb_par = W'(50);
        tick();
        par_go = 1'b0;
        tick(); tick(); tick();
        ser_en = 1'b0;
        repeat (W) tick();
        check("R5 strobe wins", sum_word, 71);
        check("R5 done flag", sum_ok, 1);

        ser_add(37, 30, 7);
        ser_add(64'hF_0F0F, 64'h0_F0F1, 21);
        ser_add(64'h3FF, 64'h1, 11);

        // R8: enable dropped mid-stream, then a fresh stream
        ser_en = 1'b1; opa_bit = 1'b1; opb_bit = 1'b1;
        repeat (W + 4) tick();
        ser_en = 1'b0;
        @(negedge clk);
        check("R8 drop mid-stream", sum_ok, 0);
        tick(); tick();
        ser_add(5, 3, 4);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        wait (cycles > 20000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule